// File: doc/BRIEF.md
# Static Time-Sliced Memory Arbiter

This block shares one memory port among a fixed set of processor cores. It does not arbitrate on demand. It follows a schedule that is decided before run time. The schedule is a table of slices, and each slice names one owner core and a length in cycles. The arbiter walks the table in order and wraps back to the first entry after the last one, so the schedule repeats with a period equal to the sum of all slice lengths. Slices may differ in length. A core can therefore get one short slice per period, or a larger share of bandwidth than the other cores.

Only the owner of the current slice can reach memory. A slice whose owner has nothing to do stays idle and is not handed to another core. A transfer begins only if it can finish before its slice ends. As a result, the time any core waits for memory depends only on the table and on when that core issues its own request. What the other cores do has no effect.

Software loads the table while the arbiter is stopped. Enabling the arbiter starts the schedule at entry 0. For each core, an output gives the number of cycles until that core's next slice begins. A system integrator or a testbench can use it to confirm latency bounds.

Top module: `slice_mem_arbiter`

## Requirements
- R1: While in reset or while not running, the grant vector is all zero, the memory request is low, no core acknowledge is raised, and every wait output is all ones.
- R2: Table entries (owner, length) and the last-entry index are written only while `en` is low and the arbiter has stopped. A write attempted while running leaves the schedule unchanged.
- R3: In the first cycle after `en` is sampled high, entry 0 is active. Each entry stays active for exactly its length in cycles. After the entry whose index equals the last-entry index, the schedule wraps to entry 0.
- R4: While running, the grant vector is one-hot, with bit i set when core i owns the current slice. It changes only at slice boundaries.
- R5: Only the owner of the current slice can start a memory transfer. When the owner is idle, the memory request stays low for the whole slice, even if other cores are waiting.
- R6: A transfer starts in a cycle where the owner requests and the current slice has at least ACCESS_CYC (default 3) cycles left, counting the current cycle. The memory request is high from the next cycle until `mem_ack`. With a memory that acknowledges on the second cycle of its request, the core acknowledge arrives two cycles after the start. Otherwise the request waits for that core's next slice.
- R7: The cycle in which a core's access completes depends only on the table and on that core's own request time. Traffic from other cores does not change it.
- R8: On a write, the core's address and data reach memory with the write enable high. On a read, memory read data is presented on the requesting core's read-data port in the same cycle as its acknowledge.
- R9: While running, a core's wait output is 0 when that core owns the current slice. Otherwise it is the number of cycles until the next slice that core owns begins. It is all ones if the core owns no entry.
- R10: At most one core acknowledge is high in any cycle, and only the core that issued the transfer receives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; table writes accepted only while low and stopped |
| cfg_we | input | 1 | Write strobe for one table entry |
| cfg_idx | input | SLOT_W | Entry index for a table write, or the new last-entry index |
| cfg_owner | input | CORE_W | Owner core of the entry being written |
| cfg_len | input | LEN_W | Slice length in cycles (0 is stored as 1) |
| cfg_last_we | input | 1 | Strobe that loads `cfg_idx` as the last-entry index |
| core_req | input | NUM_CORES | Per-core access request, held until acknowledge |
| core_we | input | NUM_CORES | Per-core write enable |
| core_addr | input | NUM_CORES x ADDR_W | Per-core address |
| core_wdata | input | NUM_CORES x DATA_W | Per-core write data |
| core_ack | output | NUM_CORES | Per-core completion pulse |
| core_rdata | output | NUM_CORES x DATA_W | Per-core read data, valid with acknowledge |
| gnt | output | NUM_CORES | One-hot owner of the current slice |
| wait_cyc | output | NUM_CORES x WAIT_W | Cycles until each core's next slice begins |
| mem_req | output | 1 | Shared memory request |
| mem_we | output | 1 | Shared memory write enable |
| mem_addr | output | ADDR_W | Shared memory address |
| mem_wdata | output | DATA_W | Shared memory write data |
| mem_ack | input | 1 | Shared memory completion |
| mem_rdata | input | DATA_W | Shared memory read data |

## Verification
A slice counter that is off by one, or that wraps at the wrong entry, shows up on the grant vector at the first wrong boundary. It also shows up on the wait outputs in the same cycle, because those outputs count down to boundaries. The bench therefore compares every cycle of two full periods against a step-by-step schedule model. A wrong fit test or a wrong transfer owner shows up only when the request is served, which can be a full period later. For that reason the acknowledge cycles are checked to the exact cycle, the memory request is watched through an idle owner's slice, and a core that owns only a one-cycle slice must never be served.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

    parameter int unsigned NUM_CORES = 4;
    parameter int unsigned MAX_SLOTS = 16;
    parameter int unsigned LEN_W     = 8;

    localparam int unsigned CORE_W = $clog2(NUM_CORES);
    localparam int unsigned SLOT_W = $clog2(MAX_SLOTS);
    localparam int unsigned WAIT_W = LEN_W + SLOT_W;

    typedef logic [CORE_W-1:0] core_id_t;
    typedef logic [SLOT_W-1:0] slot_idx_t;
    typedef logic [LEN_W-1:0]  slot_len_t;
    typedef logic [WAIT_W-1:0] wait_t;

    typedef struct packed {
        core_id_t  owner;
        slot_len_t len;
    } slot_t;

    typedef enum logic {
        XF_IDLE = 1'b0,
        XF_BUSY = 1'b1
    } xfer_state_e;

    function automatic slot_idx_t next_slot(slot_idx_t cur, slot_idx_t last);
        return (cur == last) ? '0 : slot_idx_t'(cur + 1'b1);
    endfunction

    function automatic logic [NUM_CORES-1:0] core_onehot(core_id_t id);
        logic [NUM_CORES-1:0] v;
        v = '0;
        v[id] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/tsa_slot_table.sv
module tsa_slot_table
    import tsa_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_allow,
    input  logic                        cfg_we,
    input  logic                        cfg_last_we,
    input  slot_idx_t                   cfg_idx,
    input  core_id_t                    cfg_owner,
    input  slot_len_t                   cfg_len,
    output slot_t [MAX_SLOTS-1:0]       tab,
    output slot_idx_t                   last
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MAX_SLOTS; i++) begin
                tab[i].owner <= '0;
                tab[i].len   <= slot_len_t'(1);
            end
            last <= '0;
        end else if (wr_allow) begin
            if (cfg_we) begin
                tab[cfg_idx].owner <= cfg_owner;
                tab[cfg_idx].len   <= (cfg_len == '0) ? slot_len_t'(1) : cfg_len;
            end
            if (cfg_last_we) begin
                last <= cfg_idx;
            end
        end
    end

    // Schedule is frozen while the arbiter runs
    assert_table_lock_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_allow) |-> ($stable(tab) && $stable(last)));

endmodule

// File: rtl/tsa_slot_seq.sv
module tsa_slot_seq
    import tsa_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  slot_t [MAX_SLOTS-1:0] tab,
    input  slot_idx_t             last,
    output slot_idx_t             idx,
    output slot_len_t             left,
    output core_id_t              owner
);

    slot_idx_t nxt;

    always_comb begin
        nxt   = next_slot(idx, last);
        owner = tab[idx].owner;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            idx  <= '0;
            left <= tab[0].len;
        end else if (left == slot_len_t'(1)) begin
            idx  <= nxt;
            left <= tab[nxt].len;
        end else begin
            left <= left - 1'b1;
        end
    end

    assert_left_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        run |-> (left != '0));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && $past(left) == slot_len_t'(1) && $past(idx) == $past(last))
        |-> (idx == '0));

endmodule

// File: rtl/tsa_wait_calc.sv
module tsa_wait_calc
    import tsa_pkg::*;
#(
    parameter int unsigned CORE_ID = 0
)(
    input  logic                  run,
    input  slot_t [MAX_SLOTS-1:0] tab,
    input  slot_idx_t             last,
    input  slot_idx_t             idx,
    input  slot_len_t             left,
    output wait_t                 wait_out
);

    localparam core_id_t MY_ID = core_id_t'(CORE_ID);

    wait_t     acc;
    slot_idx_t j;
    logic      found;

    always_comb begin
        wait_out = '1;
        acc      = wait_t'(left);
        j        = idx;
        found    = 1'b0;
        if (run) begin
            if (tab[idx].owner == MY_ID) begin
                wait_out = '0;
                found    = 1'b1;
            end
            for (int k = 0; k < MAX_SLOTS; k++) begin
                j = next_slot(j, last);
                if (!found && tab[j].owner == MY_ID) begin
                    wait_out = acc;
                    found    = 1'b1;
                end
                acc = acc + wait_t'(tab[j].len);
            end
        end
    end

endmodule

// File: rtl/tsa_xfer_engine.sv
module tsa_xfer_engine
    import tsa_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ACCESS_CYC = 3
)(
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                run,
    input  core_id_t                            owner,
    input  slot_len_t                           left,
    input  logic [NUM_CORES-1:0]                core_req,
    input  logic [NUM_CORES-1:0]                core_we,
    input  logic [NUM_CORES-1:0][ADDR_W-1:0]    core_addr,
    input  logic [NUM_CORES-1:0][DATA_W-1:0]    core_wdata,
    output logic [NUM_CORES-1:0]                core_ack,
    output logic [NUM_CORES-1:0][DATA_W-1:0]    core_rdata,
    output logic                                mem_req,
    output logic                                mem_we,
    output logic [ADDR_W-1:0]                   mem_addr,
    output logic [DATA_W-1:0]                   mem_wdata,
    input  logic                                mem_ack,
    input  logic [DATA_W-1:0]                   mem_rdata
);

    localparam slot_len_t FIT_MIN = slot_len_t'(ACCESS_CYC);

    xfer_state_e st;
    core_id_t    cur;
    logic        start;

    always_comb begin
        start = run && (st == XF_IDLE) && core_req[owner] && (left >= FIT_MIN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= XF_IDLE;
            cur       <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            case (st)
                XF_IDLE: if (start) begin
                    st        <= XF_BUSY;
                    cur       <= owner;
                    mem_we    <= core_we[owner];
                    mem_addr  <= core_addr[owner];
                    mem_wdata <= core_wdata[owner];
                end
                XF_BUSY: if (mem_ack) begin
                    st <= XF_IDLE;
                end
                default: st <= XF_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req  = (st == XF_BUSY);
        core_ack = (st == XF_BUSY && mem_ack) ? core_onehot(cur) : '0;
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_rdata
        assign core_rdata[c] = mem_rdata;
    end

    // A transfer in flight always belongs to the slice owner
    assert_owner_match_R5: assert property (@(posedge clk) disable iff (rst)
        (st == XF_BUSY) |-> (run && owner == cur));

    // Transfer must finish inside its slice
    assert_in_slice_R6: assert property (@(posedge clk) disable iff (rst)
        (st == XF_BUSY && left == slot_len_t'(1)) |-> mem_ack);

    assert_ack_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(core_ack));

endmodule

// File: rtl/slice_mem_arbiter.sv
module slice_mem_arbiter
    import tsa_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ACCESS_CYC = 3
)(
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                en,
    input  logic                                cfg_we,
    input  logic [SLOT_W-1:0]                   cfg_idx,
    input  logic [CORE_W-1:0]                   cfg_owner,
    input  logic [LEN_W-1:0]                    cfg_len,
    input  logic                                cfg_last_we,
    input  logic [NUM_CORES-1:0]                core_req,
    input  logic [NUM_CORES-1:0]                core_we,
    input  logic [NUM_CORES-1:0][ADDR_W-1:0]    core_addr,
    input  logic [NUM_CORES-1:0][DATA_W-1:0]    core_wdata,
    output logic [NUM_CORES-1:0]                core_ack,
    output logic [NUM_CORES-1:0][DATA_W-1:0]    core_rdata,
    output logic [NUM_CORES-1:0]                gnt,
    output logic [NUM_CORES-1:0][WAIT_W-1:0]    wait_cyc,
    output logic                                mem_req,
    output logic                                mem_we,
    output logic [ADDR_W-1:0]                   mem_addr,
    output logic [DATA_W-1:0]                   mem_wdata,
    input  logic                                mem_ack,
    input  logic [DATA_W-1:0]                   mem_rdata
);

    logic                  run;
    logic                  wr_allow;
    slot_t [MAX_SLOTS-1:0] tab;
    slot_idx_t             last;
    slot_idx_t             idx;
    slot_len_t             left;
    core_id_t              owner;

    always_ff @(posedge clk) begin
        if (rst) run <= 1'b0;
        else     run <= en;
    end

    always_comb begin
        wr_allow = !en && !run;
        gnt      = run ? core_onehot(owner) : '0;
    end

    tsa_slot_table u_table (
        .clk        (clk),
        .rst        (rst),
        .wr_allow   (wr_allow),
        .cfg_we     (cfg_we),
        .cfg_last_we(cfg_last_we),
        .cfg_idx    (cfg_idx),
        .cfg_owner  (cfg_owner),
        .cfg_len    (cfg_len),
        .tab        (tab),
        .last       (last)
    );

    tsa_slot_seq u_seq (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tab  (tab),
        .last (last),
        .idx  (idx),
        .left (left),
        .owner(owner)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_wait
        tsa_wait_calc #(.CORE_ID(c)) u_wait (
            .run     (run),
            .tab     (tab),
            .last    (last),
            .idx     (idx),
            .left    (left),
            .wait_out(wait_cyc[c])
        );
    end

    tsa_xfer_engine #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .ACCESS_CYC(ACCESS_CYC)
    ) u_xfer (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .owner     (owner),
        .left      (left),
        .core_req  (core_req),
        .core_we   (core_we),
        .core_addr (core_addr),
        .core_wdata(core_wdata),
        .core_ack  (core_ack),
        .core_rdata(core_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata)
    );

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !run |-> (gnt == '0 && core_ack == '0));

    assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        run |-> $onehot(gnt));

    assert_grant_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && $past(left) != slot_len_t'(1)) |-> $stable(gnt));

    assert_owner_wait_zero_R9: assert property (@(posedge clk) disable iff (rst)
        run |-> (wait_cyc[owner] == '0));

endmodule

// File: tb/slice_mem_arbiter_test.sv
module slice_mem_arbiter_test;
    import tsa_pkg::*;

    localparam int AW = 16;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic cfg_we = 1'b0;
    logic cfg_last_we = 1'b0;
    logic [SLOT_W-1:0] cfg_idx = '0;
    logic [CORE_W-1:0] cfg_owner = '0;
    logic [LEN_W-1:0]  cfg_len = '0;
    logic [NUM_CORES-1:0] core_req = '0;
    logic [NUM_CORES-1:0] core_we = '0;
    logic [NUM_CORES-1:0][AW-1:0] core_addr = '0;
    logic [NUM_CORES-1:0][DW-1:0] core_wdata = '0;
    logic [NUM_CORES-1:0] core_ack;
    logic [NUM_CORES-1:0][DW-1:0] core_rdata;
    logic [NUM_CORES-1:0] gnt;
    logic [NUM_CORES-1:0][WAIT_W-1:0] wait_cyc;
    logic mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    always #4 clk = ~clk;

    slice_mem_arbiter uut (
        .clk(clk), .rst(rst), .en(en),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_owner(cfg_owner),
        .cfg_len(cfg_len), .cfg_last_we(cfg_last_we),
        .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
        .core_wdata(core_wdata), .core_ack(core_ack), .core_rdata(core_rdata),
        .gnt(gnt), .wait_cyc(wait_cyc),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Memory model: acknowledges on the second cycle of each request
    logic [DW-1:0] mem_arr [16];
    logic ack_q;
    always @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else begin
            ack_q <= mem_req && !ack_q;
            if (mem_req && ack_q && mem_we) mem_arr[mem_addr[3:0]] <= mem_wdata;
        end
    end
    assign mem_ack   = ack_q;
    assign mem_rdata = mem_arr[mem_addr[3:0]];

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // Schedule model
    int e_own [16];
    int e_len [16];
    int e_last;
    int e_s, e_l;
    int k;
    bit running = 1'b0;

    int ack_at [NUM_CORES];
    logic [DW-1:0] rd_at [NUM_CORES];
    int mreq_first;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic m_adv();
        if (e_l == 1) begin
            e_s = (e_s == e_last) ? 0 : e_s + 1;
            e_l = e_len[e_s];
        end else e_l--;
    endtask

    task automatic tick();
        @(negedge clk);
        k++;
        if (running) m_adv();
    endtask

    function automatic int exp_wait(input int c);
        int s, l;
        if (e_own[e_s] == c) return 0;
        s = e_s; l = e_l;
        for (int n = 1; n < 5000; n++) begin
            if (l == 1) begin
                s = (s == e_last) ? 0 : s + 1;
                l = e_len[s];
                if (e_own[s] == c) return n;
            end else l--;
        end
        return (1 << WAIT_W) - 1;
    endfunction

    task automatic load_table(input int own[16], input int len[16], input int last);
        for (int i = 0; i <= last; i++) begin
            cfg_we = 1'b1; cfg_idx = SLOT_W'(i);
            cfg_owner = CORE_W'(own[i]); cfg_len = LEN_W'(len[i]);
            @(negedge clk);
            e_own[i] = own[i]; e_len[i] = len[i];
        end
        cfg_we = 1'b0;
        cfg_last_we = 1'b1; cfg_idx = SLOT_W'(last);
        @(negedge clk);
        cfg_last_we = 1'b0;
        e_last = last;
        @(negedge clk);
    endtask

    task automatic start_run();
        en = 1'b1;
        @(negedge clk);
        k = 0; running = 1'b1; e_s = 0; e_l = e_len[0];
    endtask

    task automatic stop_run();
        en = 1'b0; running = 1'b0;
        core_req = '0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clear_obs();
        for (int c = 0; c < NUM_CORES; c++) ack_at[c] = -1;
        mreq_first = -1;
    endtask

    // Observe cycles k .. kend-1; optionally compare grant and wait outputs to model
    task automatic watch(input int kend, input bit sched_chk, input string req);
        while (k < kend) begin
            bit ok;
            ok = 1'b1;
            if (sched_chk) begin
                if (gnt != NUM_CORES'(1 << e_own[e_s])) ok = 1'b0;
                for (int c = 0; c < NUM_CORES; c++)
                    if (int'(wait_cyc[c]) != exp_wait(c)) ok = 1'b0;
                chk(ok, req, longint'(gnt), longint'(1 << e_own[e_s]));
            end
            if (mem_req && mreq_first < 0) mreq_first = k;
            for (int c = 0; c < NUM_CORES; c++) begin
                if (core_ack[c] && ack_at[c] < 0) begin
                    ack_at[c] = k;
                    rd_at[c] = core_rdata[c];
                    core_req[c] = 1'b0;
                end
            end
            tick();
        end
    endtask

    int t1_own [16] = '{0, 1, 2, 0, 0,0,0,0,0,0,0,0,0,0,0,0};
    int t1_len [16] = '{3, 5, 3, 4, 1,1,1,1,1,1,1,1,1,1,1,1};
    int t2_own [16] = '{3, 1, 0,0,0,0,0,0,0,0,0,0,0,0,0,0};
    int t2_len [16] = '{3, 1, 1,1,1,1,1,1,1,1,1,1,1,1,1,1};

    task automatic test_reset();
        bit ok;
        ok = (gnt == '0) && !mem_req && (core_ack == '0);
        for (int c = 0; c < NUM_CORES; c++) if (wait_cyc[c] != '1) ok = 1'b0;
        chk(ok, "R1 reset/stopped outputs", longint'(gnt), 0);
    endtask

    task automatic test_schedule();
        start_run();
        clear_obs();
        watch(32, 1'b1, "R3 R4 R9 grant/wait vs schedule");
        chk(mreq_first == -1, "R5 no request, no memory access", mreq_first, -1);
        stop_run();
        test_reset();
    endtask

    task automatic test_fit_and_idle();
        start_run();
        clear_obs();
        tick();
        core_req[0] = 1'b1;
        watch(3, 1'b0, "");
        core_req[2] = 1'b1;
        watch(16, 1'b0, "");
        chk(mreq_first == 9, "R5 idle owner slice not given away", mreq_first, 9);
        chk(ack_at[2] == 10, "R6 core2 served in own slice", ack_at[2], 10);
        chk(ack_at[0] == 13, "R6 no-fit request waits for next slice", ack_at[0], 13);
        stop_run();
    endtask

    task automatic test_independence();
        int alone;
        start_run();
        clear_obs();
        core_req[1] = 1'b1;
        watch(8, 1'b0, "");
        alone = ack_at[1];
        chk(alone == 5, "R7 core1 alone", alone, 5);
        stop_run();
        start_run();
        clear_obs();
        core_req[0] = 1'b1; core_req[1] = 1'b1; core_req[2] = 1'b1;
        watch(11, 1'b0, "");
        chk(ack_at[1] == alone, "R7 core1 unaffected by others", ack_at[1], alone);
        chk(ack_at[0] == 2, "R6 core0 start at slice start", ack_at[0], 2);
        chk(ack_at[2] == 10, "R10 core2 own ack", ack_at[2], 10);
        stop_run();
    endtask

    task automatic test_data();
        start_run();
        clear_obs();
        core_we[1] = 1'b1; core_addr[1] = AW'(5); core_wdata[1] = 32'hA5A5_0001;
        core_req[1] = 1'b1;
        watch(6, 1'b0, "");
        chk(ack_at[1] == 5, "R8 write completes", ack_at[1], 5);
        clear_obs();
        core_we[1] = 1'b0; core_wdata[1] = '0;
        core_req[1] = 1'b1;
        watch(22, 1'b0, "");
        chk(ack_at[1] == 20, "R3 read waits one period", ack_at[1], 20);
        chk(rd_at[1] == 32'hA5A5_0001, "R8 read data returned", longint'(rd_at[1]), 32'hA5A5_0001);
        // write attempt while running must be ignored
        cfg_we = 1'b1; cfg_idx = SLOT_W'(1); cfg_owner = CORE_W'(3); cfg_len = LEN_W'(2);
        tick();
        cfg_we = 1'b0;
        stop_run();
        start_run();
        clear_obs();
        watch(20, 1'b1, "R2 running write ignored");
        stop_run();
    endtask

    task automatic test_short_slice();
        load_table(t2_own, t2_len, 1);
        start_run();
        clear_obs();
        core_req[1] = 1'b1;
        watch(12, 1'b1, "R9 R3 second table schedule");
        chk(ack_at[1] == -1, "R6 one-cycle slice never serves", ack_at[1], -1);
        chk(mreq_first == -1, "R6 no memory request in short slice", mreq_first, -1);
        stop_run();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mem_arr[i] = '0;
        repeat (3) @(negedge clk);
        test_reset();
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        load_table(t1_own, t1_len, 3);
        test_schedule();
        test_fit_and_idle();
        test_independence();
        test_data();
        test_short_slice();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule